// File: doc/BRIEF.md
# Sequential Booth Multiplier

This block multiplies two operands of `W` bits each and returns the full product of `2W` bits. It works one bit at a time over several cycles. It uses radix-2 Booth recoding, and a mode input selects whether the operands are read as two's-complement or as unsigned values. A caller sets `start` high for one cycle while the block is idle and drives the operands and the mode at the same time. The block then raises `busy`. After `W+1` working cycles it lowers `busy` and pulses `done`. The result stays on the outputs until the next accepted start.

Inside, the block keeps a single accumulator. Its upper part gathers the partial sums, its lower part starts out holding the multiplier, and one extra bit sits below bit 0. In each working cycle the block reads the lowest multiplier bit together with the extra bit and picks one of three actions: add the multiplicand into the upper part, subtract it, or leave the upper part alone. The whole register then shifts one place to the right, and the sign bit is copied into the top. Before any work starts, both operands are widened by one bit: with a copy of their sign in signed mode, or with a zero in unsigned mode. One recoding pass therefore covers both modes.

The result comes out as a full-width word and also as separate upper and lower halves. An overflow flag tells whether the product fits in `W` bits when the operands are read in the selected mode.

Top module: `booth_mult`

## Requirements
- R1: While reset is held and right after it, `busy`, `done`, `ovf` and `product` are all zero.
- R2: A `start` seen while `busy` is low is accepted. `busy` is high in the next cycle. `done` rises exactly `W+1` cycles after the load cycle.
- R3: With `op_unsigned` = 0, `product` equals the two's-complement product of `mcand` and `mplier`, for example 0010 × 1101 = 1111_1010 when W = 4.
- R4: With `op_unsigned` = 1, `product` equals the unsigned product of `mcand` and `mplier`.
- R5: `done` is high for exactly one cycle. `busy` is low in that same cycle.
- R6: A `start` pulse while `busy` is high is ignored. The running job finishes on its original schedule and with its original operands and mode.
- R7: `prod_hi` equals `product[2W-1:W]` and `prod_lo` equals `product[W-1:0]`.
- R8: In unsigned mode, `ovf` is 1 exactly when `prod_hi` is non-zero.
- R9: In signed mode, `ovf` is 1 exactly when `prod_hi` is not W copies of `prod_lo[W-1]`.
- R10: While the block is idle and no start is accepted, `product` and `ovf` keep their values, whatever the operand inputs do.
- R11: The most negative operands give correct results. With W = 4, signed −8 × −8 = 0x40 with `ovf` = 1, signed −8 × 7 = 0xC8 with `ovf` = 1, and unsigned 15 × 15 = 0xE1 with `ovf` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a multiplication (taken only while idle) |
| op_unsigned | input | 1 | 1 = operands are unsigned, 0 = two's-complement |
| mcand | input | W | Multiplicand |
| mplier | input | W | Multiplier |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| product | output | 2W | Full product |
| prod_hi | output | W | Upper half of the product |
| prod_lo | output | W | Lower half of the product |
| ovf | output | 1 | Product does not fit in W bits in the selected mode |

## Verification
The bench builds the block with W = 4. That makes the full operand space of 256 pairs small enough to run in both signed and unsigned mode. Every recoding pattern, every carry into the guard bits, every most-negative case and every overflow boundary is therefore applied and compared against products the bench computes itself. With W = 4 the worked example 0010 × 1101 can also be checked bit for bit. The latency of W+1 working cycles stays short enough that a start arriving in the middle of a job can be placed at a known cycle.

// File: rtl/booth_pkg.sv
// Shared types for the sequential Booth multiplier.
// Assumes nothing beyond IEEE 1800-2017 packages.
package booth_pkg;

    // Action chosen for one iteration from the recoded bit pair.
    typedef enum logic [1:0] {
        BOP_SKIP = 2'd0,
        BOP_ADD  = 2'd1,
        BOP_SUB  = 2'd2
    } booth_op_e;

endpackage

// File: rtl/booth_recode.sv
// Radix-2 Booth recoder.
// Looks at the current lowest multiplier bit and the bit that was shifted out
// below it, and picks the action for the upper accumulator half.
// Assumes: pure combinational logic, no state.
module booth_recode
    import booth_pkg::*;
(
    input  logic      cur_bit,
    input  logic      prev_bit,
    output booth_op_e op
);

    // Map the bit pair to add, subtract or skip.
    always_comb begin
        unique case ({cur_bit, prev_bit})
            2'b01:   op = BOP_ADD;
            2'b10:   op = BOP_SUB;
            default: op = BOP_SKIP;
        endcase
    end

endmodule

// File: rtl/booth_step.sv
// One Booth iteration on the accumulator: an optional add or subtract of the
// multiplicand into the upper part, followed by an arithmetic shift right by one
// of the whole {upper, lower, extra} register.
// Assumes: the upper part has two guard bits above the operand width, so the
// partial sums never wrap.
module booth_step
    import booth_pkg::*;
#(
    parameter int HW = 34,
    parameter int LW = 33
) (
    input  logic [HW-1:0] hi_in,
    input  logic [LW-1:0] lo_in,
    input  logic [HW-1:0] mc_in,
    input  booth_op_e     op,
    output logic [HW-1:0] hi_out,
    output logic [LW-1:0] lo_out,
    output logic          xb_out
);

    logic [HW-1:0] sum;

    // Add to, subtract from, or pass the upper part.
    always_comb begin
        unique case (op)
            BOP_ADD: sum = hi_in + mc_in;
            BOP_SUB: sum = hi_in - mc_in;
            default: sum = hi_in;
        endcase
    end

    // Arithmetic shift right of the concatenated register.
    always_comb begin
        {hi_out, lo_out, xb_out} = {sum[HW-1], sum, lo_in};
    end

endmodule

// File: rtl/booth_seq.sv
// Sequencer for the iterative multiplier.
// Takes a start only when idle, runs ITER iterations one per cycle, then drops
// busy and pulses done for one cycle.
// Assumes: synchronous active-low reset; ITER >= 1.
module booth_seq #(
    parameter int ITER = 33
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);

    localparam int CW = $clog2(ITER + 1);

    logic [CW-1:0] cnt_q;

    assign load = start && !busy;
    assign step = busy;

    // Count iterations and produce busy and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            cnt_q <= '0;
        end else begin
            done <= 1'b0;
            if (load) begin
                busy  <= 1'b1;
                cnt_q <= '0;
            end else if (busy) begin
                if (cnt_q == CW'(ITER - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/booth_mult.sv
// Sequential radix-2 Booth multiplier, signed or unsigned, W x W -> 2W.
// Operands are widened by one bit (a copy of the sign, or zero) so that one
// recoding scheme serves both modes. The job takes W+1 iterations.
// Assumes: start is honoured only while idle; the outputs hold the last result
// until the next accepted start.
module booth_mult
    import booth_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           op_unsigned,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] product,
    output logic [W-1:0]   prod_hi,
    output logic [W-1:0]   prod_lo,
    output logic           ovf
);

    localparam int LW = W + 1;
    localparam int HW = W + 2;
    localparam int PW = HW + LW;

    logic          load, step;
    logic [HW-1:0] hi_q, mc_q, hi_nx;
    logic [LW-1:0] lo_q, lo_nx;
    logic          xb_q, xb_nx, uns_q;
    logic          mc_ext, mp_ext;
    booth_op_e     op;
    logic [PW-1:0] acc;

    booth_seq #(.ITER(LW)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    booth_recode u_rec (
        .cur_bit  (lo_q[0]),
        .prev_bit (xb_q),
        .op       (op)
    );

    booth_step #(.HW(HW), .LW(LW)) u_step (
        .hi_in  (hi_q),
        .lo_in  (lo_q),
        .mc_in  (mc_q),
        .op     (op),
        .hi_out (hi_nx),
        .lo_out (lo_nx),
        .xb_out (xb_nx)
    );

    // Bit used to widen each operand, chosen by the mode.
    always_comb begin
        mc_ext = op_unsigned ? 1'b0 : mcand[W-1];
        mp_ext = op_unsigned ? 1'b0 : mplier[W-1];
    end

    // Accumulator: load on an accepted start, one iteration per busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q  <= '0;
            lo_q  <= '0;
            xb_q  <= 1'b0;
            mc_q  <= '0;
            uns_q <= 1'b0;
        end else if (load) begin
            hi_q  <= '0;
            lo_q  <= {mp_ext, mplier};
            xb_q  <= 1'b0;
            mc_q  <= {{2{mc_ext}}, mcand};
            uns_q <= op_unsigned;
        end else if (step) begin
            hi_q <= hi_nx;
            lo_q <= lo_nx;
            xb_q <= xb_nx;
        end
    end

    // Present the result and its halves, and flag overflow of a W-bit result.
    always_comb begin
        acc     = {hi_q, lo_q};
        product = acc[2*W-1:0];
        prod_hi = product[2*W-1:W];
        prod_lo = product[W-1:0];
        if (uns_q)
            ovf = (prod_hi != '0);
        else
            ovf = (prod_hi != {W{prod_lo[W-1]}});
    end

endmodule

// File: rtl/booth_mult_chk.sv
// Protocol checker for booth_mult, attached to every instance by bind.
// Assumes: synchronous active-low reset.
module booth_mult_chk #(
    parameter int W = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic [2*W-1:0] product,
    input logic           ovf
);

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    done_after_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(product) && $stable(ovf)));

endmodule

bind booth_mult booth_mult_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .product (product),
    .ovf     (ovf)
);

// File: tb/sim_booth_mult.sv
`timescale 1ns/1ps
module sim_booth_mult;

    localparam int W = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic           op_unsigned = 1'b0;
    logic [W-1:0]   mcand = '0;
    logic [W-1:0]   mplier = '0;
    logic           busy, done, ovf;
    logic [2*W-1:0] product;
    logic [W-1:0]   prod_hi, prod_lo;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    booth_mult #(.W(W)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .op_unsigned (op_unsigned),
        .mcand       (mcand),
        .mplier      (mplier),
        .busy        (busy),
        .done        (done),
        .product     (product),
        .prod_hi     (prod_hi),
        .prod_lo     (prod_lo),
        .ovf         (ovf)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a,
                                               input logic [W-1:0] b,
                                               input logic uns);
        logic [2*W-1:0] ea, eb;
        ea = uns ? {{W{1'b0}}, a} : {{W{a[W-1]}}, a};
        eb = uns ? {{W{1'b0}}, b} : {{W{b[W-1]}}, b};
        return ea * eb;
    endfunction

    function automatic logic ref_ovf(input logic [2*W-1:0] p, input logic uns);
        if (uns) return p[2*W-1:W] != '0;
        return p[2*W-1:W] != {W{p[W-1]}};
    endfunction

    // Compare all result outputs against the reference for one job.
    task automatic check_result(input logic [W-1:0] a, input logic [W-1:0] b,
                                input logic uns);
        logic [2*W-1:0] e;
        e = ref_mul(a, b, uns);
        check(product == e, uns ? "R4 product" : "R3 product", 64'(product), 64'(e));
        check(prod_hi == e[2*W-1:W] && prod_lo == e[W-1:0], "R7 halves",
              64'({prod_hi, prod_lo}), 64'(e));
        check(ovf == ref_ovf(e, uns), uns ? "R8 ovf" : "R9 ovf",
              64'(ovf), 64'(ref_ovf(e, uns)));
    endtask

    // Run one job: start for one cycle, wait for done, check latency and result.
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic uns);
        int n;
        @(negedge clk);
        start = 1'b1; mcand = a; mplier = b; op_unsigned = uns;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 busy after start", 64'(busy), 64'd1);
        n = 1;
        while (!done && n < 60) begin
            @(posedge clk);
            @(negedge clk);
            n++;
        end
        check(n == W + 2, "R2 latency", 64'(n), 64'(W + 2));
        check(busy == 1'b0, "R5 busy low with done", 64'(busy), 64'd0);
        check_result(a, b, uns);
        @(negedge clk);
        check(done == 1'b0, "R5 done one cycle", 64'(done), 64'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && ovf == 0 && product == 0, "R1 in reset",
              64'({busy, done, ovf, product}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && done == 0 && ovf == 0 && product == 0, "R1 after reset",
              64'({busy, done, ovf, product}), 64'd0);
    endtask

    task automatic t_worked_example();
        run_op(4'b0010, 4'b1101, 1'b0);
        check(product == 8'b1111_1010, "R3 worked example", 64'(product), 64'hFA);
    endtask

    task automatic t_extremes();
        run_op(4'h8, 4'h8, 1'b0);
        check(product == 8'h40 && ovf == 1'b1, "R11 -8*-8", 64'({ovf, product}), 64'h140);
        run_op(4'h8, 4'h7, 1'b0);
        check(product == 8'hC8 && ovf == 1'b1, "R11 -8*7", 64'({ovf, product}), 64'h1C8);
        run_op(4'hF, 4'hF, 1'b1);
        check(product == 8'hE1 && ovf == 1'b1, "R11 15*15 unsigned", 64'({ovf, product}), 64'h1E1);
    endtask

    task automatic t_exhaustive(input logic uns);
        for (int a = 0; a < (1 << W); a++)
            for (int b = 0; b < (1 << W); b++)
                run_op(W'(a), W'(b), uns);
    endtask

    // R6: a second start in the middle of a job must change nothing.
    task automatic t_ignore_busy_start();
        int n;
        @(negedge clk);
        start = 1'b1; mcand = 4'h3; mplier = 4'hB; op_unsigned = 1'b0;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        n = 1;
        @(posedge clk);
        @(negedge clk);
        n++;
        start = 1'b1; mcand = 4'hF; mplier = 4'hE; op_unsigned = 1'b1;
        @(posedge clk);
        @(negedge clk);
        n++;
        start = 1'b0;
        while (!done && n < 60) begin
            @(posedge clk);
            @(negedge clk);
            n++;
        end
        check(n == W + 2, "R6 latency unchanged", 64'(n), 64'(W + 2));
        check(product == 8'hF1, "R6 original operands kept", 64'(product), 64'hF1);
        check(ovf == 1'b1, "R6 original mode kept", 64'(ovf), 64'd1);
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R6 no second job",
              64'({busy, done}), 64'd0);
    endtask

    // R10: operand changes without a start leave the result alone.
    task automatic t_hold();
        run_op(4'h6, 4'h5, 1'b1);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            mcand = W'(k + 9); mplier = W'(k * 3); op_unsigned = k[0];
        end
        @(negedge clk);
        check(product == 8'h1E, "R10 product held", 64'(product), 64'h1E);
        check(ovf == 1'b1 && busy == 1'b0, "R10 ovf held, idle", 64'({ovf, busy}), 64'h2);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_worked_example();
        t_extremes();
        t_ignore_busy_start();
        t_hold();
        t_exhaustive(1'b0);
        t_exhaustive(1'b1);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule